// File: doc/BRIEF.md
# Register-Port Access Delay Interposer

This block sits on the seam between a processor and a video controller's register port. In normal operation it samples the chip enable, the read/write line, the three register-select lines and the address-latch strobe once per half-cycle, and presents them one half-cycle later on the video side with no other change. The video controller's current scanline and dot arrive through the same sampling stage, so every decision the block makes refers to one consistent snapshot.

When it is armed and a read of data register 7 begins on the programmed scanline, inside the programmed dot range, the block corrects a propagation delay that the surrounding model otherwise treats as zero. The access is handled in three steps. First, the register select seen by the video controller is steered to a harmless register for as long as the processor's own access lasts, so the early access to register 7 never takes effect. Second, a programmable number of half-cycles after the trigger (24 by intent, one processor cycle or three dots), the block cuts the processor side off and replays the access on its own video-side lines: chip enable active and select held at 7 for a programmable number of half-cycles. Third, on the programmed freeze dot of that scanline, the outgoing latch strobe is held low for the whole dot, so an external transparent address latch keeps the byte it captured on the dot before. The next fetch then uses that stale low address byte.

The window is meant to be narrow; ordinary register-7 traffic outside it passes untouched. A counter records each intervention, and a sticky flag records any qualifying read that arrives while an earlier intervention is still in progress. Such a read is not modified.

Top module: `ai_interposer`

## Requirements
- R1: When `cfg_arm` is 0, or when no intervention is in progress and no qualifying read starts, `vid_ce_n` and `vid_rs` equal `cpu_ce_n` and `cpu_rs` as sampled one clock (half-cycle) earlier, and `ale_out` equals `ale_in` sampled one clock earlier.
- R2: A qualifying read starts on the first sampled half-cycle in which `cpu_ce_n`=0, `cpu_rw`=1 and `cpu_rs`=7 after a half-cycle in which these did not all hold, with `cfg_arm`=1, sampled line equal to `cfg_line` and sampled dot within `cfg_dot_lo`..`cfg_dot_hi` inclusive. For every half-cycle of that access `vid_rs` shows the harmless value 0 while `vid_ce_n` follows the processor, and `fire_count` increments by one.
- R3: Starting exactly `cfg_delay` half-cycles after the trigger half-cycle, `vid_ce_n` is 0 and `vid_rs` is 7 for exactly `cfg_hold` half-cycles, after which pass-through resumes.
- R4: During the replay the processor-side chip enable and register select have no effect on `vid_ce_n` or `vid_rs`.
- R5: After an intervention, `ale_out` is 0 for every half-cycle whose sampled dot equals `cfg_freeze_dot` on `cfg_line`, whatever `ale_in` does; outside that dot `ale_out` follows R1.
- R6: With a transparent latch loaded while `ale_out`=1, the latch content on the dot after the freeze dot is the byte captured on the dot before it, so a fetch address formed as 0x0F00 plus the latch byte reads 0x0FFF when that byte was 0xFF.
- R7: Register-7 reads outside the programmed dot window, or while disarmed, are not intercepted and leave `fire_count` unchanged.
- R8: A qualifying read that starts while an intervention (swallow, wait, replay or pending freeze) is in progress is not modified in its pass-through half-cycles, does not increment `fire_count`, and sets `overlap`, which stays 1 until reset.
- R9: After reset `vid_ce_n`=1, `vid_rs`=0, `ale_out`=0, `fire_count`=0 and `overlap`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_arm | input | 1 | Enables interception |
| cfg_line | input | 9 | Target scanline |
| cfg_dot_lo | input | 9 | First dot of trigger window |
| cfg_dot_hi | input | 9 | Last dot of trigger window |
| cfg_delay | input | DLY_W | Half-cycles from trigger to replay start |
| cfg_hold | input | DLY_W | Replay length in half-cycles |
| cfg_freeze_dot | input | 9 | Dot on which the latch strobe is held low |
| cur_line | input | 9 | Video controller scanline |
| cur_dot | input | 9 | Video controller dot |
| cpu_ce_n | input | 1 | Processor-side chip enable, active low |
| cpu_rw | input | 1 | Processor-side read (1) / write (0) |
| cpu_rs | input | 3 | Processor-side register select |
| ale_in | input | 1 | Latch strobe from video controller |
| vid_ce_n | output | 1 | Video-side chip enable, active low |
| vid_rs | output | 3 | Video-side register select |
| ale_out | output | 1 | Latch strobe towards external latch |
| fire_count | output | CNT_W | Number of interventions, saturating |
| overlap | output | 1 | Sticky: qualifying read seen while busy |

## Verification
On every cycle the assertions check the disarmed pass-through of chip enable and select, that the latch strobe can only be high when the incoming strobe was, that the intervention counter never moves by more than one and only when the select just shown was not 7, and that the overlap flag never clears. The exact placement of the replay relative to the trigger, the ignoring of processor traffic during it, the one-dot freeze of the strobe and the stale byte it leaves in a modelled transparent latch, and the behaviour of reads just outside the window or arriving during an intervention are only shown by the bench's scenarios, which compare each affected half-cycle against queued expectations.

// File: rtl/ai_pkg.sv
package ai_pkg;

    localparam int POS_W = 9;
    localparam int RS_W  = 3;

    localparam logic [RS_W-1:0] RS_DATA = 3'd7;
    localparam logic [RS_W-1:0] RS_SAFE = 3'd0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_WAIT    = 2'd2,
        ST_REPLAY  = 2'd3
    } ai_state_e;

    typedef struct packed {
        logic             ce_n;
        logic             rw;
        logic [RS_W-1:0]  rs;
        logic [POS_W-1:0] line;
        logic [POS_W-1:0] dot;
        logic             ale;
    } ai_smp_t;

    function automatic logic is_data_read(input ai_smp_t s);
        return !s.ce_n && s.rw && (s.rs == RS_DATA);
    endfunction

    function automatic logic in_range(input logic [POS_W-1:0] v,
                                      input logic [POS_W-1:0] lo,
                                      input logic [POS_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/ai_sampler.sv
module ai_sampler
    import ai_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_ce_n,
    input  logic             cpu_rw,
    input  logic [RS_W-1:0]  cpu_rs,
    input  logic [POS_W-1:0] cur_line,
    input  logic [POS_W-1:0] cur_dot,
    input  logic             ale_in,
    output ai_smp_t          smp,
    output logic             acc,
    output logic             acc_start
);

    logic acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp.ce_n <= 1'b1;
            smp.rw   <= 1'b1;
            smp.rs   <= '0;
            smp.line <= '0;
            smp.dot  <= '0;
            smp.ale  <= 1'b0;
            acc_q    <= 1'b0;
        end else begin
            smp.ce_n <= cpu_ce_n;
            smp.rw   <= cpu_rw;
            smp.rs   <= cpu_rs;
            smp.line <= cur_line;
            smp.dot  <= cur_dot;
            smp.ale  <= ale_in;
            acc_q    <= acc;
        end
    end

    assign acc       = is_data_read(smp);
    assign acc_start = acc && !acc_q;

endmodule

// File: rtl/ai_seq.sv
module ai_seq
    import ai_pkg::*;
#(
    parameter int DLY_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_arm,
    input  logic [POS_W-1:0] cfg_line,
    input  logic [POS_W-1:0] cfg_dot_lo,
    input  logic [POS_W-1:0] cfg_dot_hi,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [DLY_W-1:0] cfg_hold,
    input  ai_smp_t          smp,
    input  logic             acc,
    input  logic             acc_start,
    input  logic             frz_pend,
    output ai_state_e        st,
    output logic             trig,
    output logic [CNT_W-1:0] fire_count,
    output logic             overlap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] rcnt;
    logic             qual;
    logic             busy;
    logic [DLY_W-1:0] delay_last;
    logic [DLY_W-1:0] hold_last;

    assign qual       = acc_start && cfg_arm && (smp.line == cfg_line)
                        && in_range(smp.dot, cfg_dot_lo, cfg_dot_hi);
    assign busy       = (st != ST_IDLE) || frz_pend;
    assign trig       = qual && !busy;
    assign delay_last = cfg_delay - DLY_W'(1);
    assign hold_last  = cfg_hold - DLY_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            rcnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (trig) begin
                        st  <= ST_SWALLOW;
                        cnt <= DLY_W'(1);
                    end
                end
                ST_SWALLOW, ST_WAIT: begin
                    cnt <= cnt + DLY_W'(1);
                    if (cnt == delay_last) begin
                        st   <= ST_REPLAY;
                        rcnt <= '0;
                    end else if (st == ST_SWALLOW && !acc) begin
                        st <= ST_WAIT;
                    end
                end
                ST_REPLAY: begin
                    rcnt <= rcnt + DLY_W'(1);
                    if (rcnt == hold_last) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_count <= '0;
            overlap    <= 1'b0;
        end else begin
            if (trig && fire_count != CNT_MAX) begin
                fire_count <= fire_count + CNT_W'(1);
            end
            if (qual && busy) begin
                overlap <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ai_freeze.sv
module ai_freeze
    import ai_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [POS_W-1:0] cfg_line,
    input  logic [POS_W-1:0] cfg_freeze_dot,
    input  ai_smp_t          smp,
    output logic             frz_pend,
    output logic             freeze
);

    logic on_line;
    logic passed;

    assign on_line = (smp.line == cfg_line);
    assign passed  = !on_line || (smp.dot > cfg_freeze_dot);
    assign freeze  = frz_pend && on_line && (smp.dot == cfg_freeze_dot);

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_pend <= 1'b0;
        end else if (trig) begin
            frz_pend <= 1'b1;
        end else if (frz_pend && passed) begin
            frz_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/ai_interposer.sv
module ai_interposer
    import ai_pkg::*;
#(
    parameter int DLY_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_arm,
    input  logic [POS_W-1:0] cfg_line,
    input  logic [POS_W-1:0] cfg_dot_lo,
    input  logic [POS_W-1:0] cfg_dot_hi,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [DLY_W-1:0] cfg_hold,
    input  logic [POS_W-1:0] cfg_freeze_dot,
    input  logic [POS_W-1:0] cur_line,
    input  logic [POS_W-1:0] cur_dot,
    input  logic             cpu_ce_n,
    input  logic             cpu_rw,
    input  logic [RS_W-1:0]  cpu_rs,
    input  logic             ale_in,
    output logic             vid_ce_n,
    output logic [RS_W-1:0]  vid_rs,
    output logic             ale_out,
    output logic [CNT_W-1:0] fire_count,
    output logic             overlap
);

    ai_smp_t   smp;
    logic      acc;
    logic      acc_start;
    ai_state_e st;
    logic      trig;
    logic      frz_pend;
    logic      freeze;

    ai_sampler u_smp (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce_n  (cpu_ce_n),
        .cpu_rw    (cpu_rw),
        .cpu_rs    (cpu_rs),
        .cur_line  (cur_line),
        .cur_dot   (cur_dot),
        .ale_in    (ale_in),
        .smp       (smp),
        .acc       (acc),
        .acc_start (acc_start)
    );

    ai_seq #(
        .DLY_W (DLY_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_arm    (cfg_arm),
        .cfg_line   (cfg_line),
        .cfg_dot_lo (cfg_dot_lo),
        .cfg_dot_hi (cfg_dot_hi),
        .cfg_delay  (cfg_delay),
        .cfg_hold   (cfg_hold),
        .smp        (smp),
        .acc        (acc),
        .acc_start  (acc_start),
        .frz_pend   (frz_pend),
        .st         (st),
        .trig       (trig),
        .fire_count (fire_count),
        .overlap    (overlap)
    );

    ai_freeze u_frz (
        .clk            (clk),
        .rst            (rst),
        .trig           (trig),
        .cfg_line       (cfg_line),
        .cfg_freeze_dot (cfg_freeze_dot),
        .smp            (smp),
        .frz_pend       (frz_pend),
        .freeze         (freeze)
    );

    // Video-side bus: replay owns the lines outright; swallow only steers
    // the select away from the data register.
    always_comb begin
        vid_ce_n = smp.ce_n;
        vid_rs   = smp.rs;
        if (st == ST_REPLAY) begin
            vid_ce_n = 1'b0;
            vid_rs   = RS_DATA;
        end else if (trig || (st == ST_SWALLOW && acc)) begin
            vid_rs = RS_SAFE;
        end
    end

    assign ale_out = smp.ale && !freeze;

endmodule

// File: rtl/ai_interposer_chk.sv
module ai_interposer_chk
    import ai_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_arm,
    input logic             cpu_ce_n,
    input logic [RS_W-1:0]  cpu_rs,
    input logic             ale_in,
    input logic             vid_ce_n,
    input logic [RS_W-1:0]  vid_rs,
    input logic             ale_out,
    input logic [CNT_W-1:0] fire_count,
    input logic             overlap,
    input ai_state_e        st,
    input logic             frz_pend
);

    // R1: disarmed and idle means a plain one-half-cycle relay
    p_relay_r1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_arm && $past(!cfg_arm) && $past(!rst) && st == ST_IDLE
         && $past(st) == ST_IDLE && !frz_pend)
        |-> (vid_rs == $past(cpu_rs) && vid_ce_n == $past(cpu_ce_n)));

    // R5: the strobe out can only be high if the strobe in was
    p_strobe_gate_r5: assert property (@(posedge clk) disable iff (rst)
        ale_out |-> ($past(ale_in) && $past(!rst)));

    // R2: each increment follows a half-cycle with the select steered off 7
    p_swallow_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && fire_count != $past(fire_count))
        |-> ($past(vid_rs) != RS_DATA));

    // R2: counter advances by one step at most
    p_fire_step_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && fire_count != $past(fire_count))
        |-> (fire_count == $past(fire_count) + CNT_W'(1)));

    // R8: overlap flag is sticky
    p_overlap_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(overlap)) |-> overlap);

endmodule

bind ai_interposer ai_interposer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_ai_interposer.sv
module test_ai_interposer;

    localparam int DLY_W = 6;
    localparam int CNT_W = 8;
    localparam int S_BEG = 1780;
    localparam int S_END = 1850;
    localparam int LINE  = 30;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_arm = 1'b0;
    logic [8:0]       cfg_line = 9'(LINE);
    logic [8:0]       cfg_dot_lo = 9'd226;
    logic [8:0]       cfg_dot_hi = 9'd226;
    logic [DLY_W-1:0] cfg_delay = 6'd24;
    logic [DLY_W-1:0] cfg_hold = 6'd8;
    logic [8:0]       cfg_freeze_dot = 9'd229;
    logic [8:0]       cur_line = 9'(LINE);
    logic [8:0]       cur_dot = '0;
    logic             cpu_ce_n = 1'b1;
    logic             cpu_rw = 1'b1;
    logic [2:0]       cpu_rs = '0;
    logic             ale_in = 1'b0;
    logic             vid_ce_n;
    logic [2:0]       vid_rs;
    logic             ale_out;
    logic [CNT_W-1:0] fire_count;
    logic             overlap;

    int   n_chk = 0;
    int   n_fail = 0;
    int   step = 0;
    logic [7:0] bus_cur = '0;
    logic [7:0] bus_d = '0;
    logic [7:0] latch_q = '0;
    logic [15:0] fetch_addr = '0;

    typedef struct {
        int    st;
        int    kind;
        int    val;
        string req;
    } exp_t;
    exp_t exq[$];

    always #5 clk = ~clk;

    ai_interposer #(.DLY_W(DLY_W), .CNT_W(CNT_W)) i_ai_interposer (
        .clk(clk), .rst(rst), .cfg_arm(cfg_arm), .cfg_line(cfg_line),
        .cfg_dot_lo(cfg_dot_lo), .cfg_dot_hi(cfg_dot_hi),
        .cfg_delay(cfg_delay), .cfg_hold(cfg_hold),
        .cfg_freeze_dot(cfg_freeze_dot), .cur_line(cur_line),
        .cur_dot(cur_dot), .cpu_ce_n(cpu_ce_n), .cpu_rw(cpu_rw),
        .cpu_rs(cpu_rs), .ale_in(ale_in), .vid_ce_n(vid_ce_n),
        .vid_rs(vid_rs), .ale_out(ale_out), .fire_count(fire_count),
        .overlap(overlap)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (step %0d)", req, act, exp, step);
        end
    endtask

    // kind: 0 = vid_ce_n, 1 = vid_rs, 2 = ale_out; st = input step reflected
    task automatic push(input int s, input int kind, input int val, input string req);
        exp_t e;
        e.st = s; e.kind = kind; e.val = val; e.req = req;
        exq.push_back(e);
    endtask

    task automatic push_bus(input int s0, input int s1, input int ce, input int rs,
                            input string req);
        for (int s = s0; s <= s1; s++) begin
            push(s, 0, ce, req);
            push(s, 1, rs, req);
        end
    endtask

    // Monitor: outputs seen at a falling edge reflect the inputs of step-1.
    always @(negedge clk) begin
        if (ale_out) latch_q <= bus_d;
        for (int i = exq.size() - 1; i >= 0; i--) begin
            if (exq[i].st == step - 1) begin
                case (exq[i].kind)
                    0: check(exq[i].req, int'(vid_ce_n), exq[i].val);
                    1: check(exq[i].req, int'(vid_rs), exq[i].val);
                    default: check(exq[i].req, int'(ale_out), exq[i].val);
                endcase
                exq.delete(i);
            end
        end
    end

    function automatic logic [7:0] bus_byte(input int dot);
        if (dot == 228) return 8'hFF;
        if (dot == 229) return 8'h04;
        return 8'(dot);
    endfunction

    task automatic run_line(input int a_beg, input int a_len, input int a_rs,
                            input int b_beg, input int b_len, input int b_rs);
        for (int s = S_BEG; s <= S_END; s++) begin
            @(posedge clk);
            #1;
            if (s == 1841) fetch_addr = 16'h0F00 | {8'h00, latch_q};
            step = s;
            cur_dot = 9'(s / 8);
            ale_in = ((s % 8) < 2);
            bus_d = bus_cur;
            bus_cur = bus_byte(s / 8);
            if (s >= a_beg && s < a_beg + a_len) begin
                cpu_ce_n = 1'b0; cpu_rs = 3'(a_rs);
            end else if (s >= b_beg && s < b_beg + b_len) begin
                cpu_ce_n = 1'b0; cpu_rs = 3'(b_rs);
            end else begin
                cpu_ce_n = 1'b1; cpu_rs = 3'd0;
            end
        end
        @(posedge clk);
        #1;
        step = S_END + 1;
        cpu_ce_n = 1'b1;
        @(negedge clk);
        #1;
        check("leftover-expectations", exq.size(), 0);
        exq.delete();
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R9: reset values
        check("R9 vid_ce_n", int'(vid_ce_n), 1);
        check("R9 vid_rs", int'(vid_rs), 0);
        check("R9 ale_out", int'(ale_out), 0);
        check("R9 fire_count", int'(fire_count), 0);
        check("R9 overlap", int'(overlap), 0);

        // R1 / R7: disarmed, register-7 read inside the window is relayed
        cfg_arm = 1'b0;
        push_bus(1810, 1815, 0, 7, "R1 disarmed relay");
        push(1824, 2, 1, "R1 strobe relay");
        push(1832, 2, 1, "R7 no freeze when disarmed");
        run_line(1810, 6, 7, 0, 0, 0);
        check("R7 fire_count disarmed", int'(fire_count), 0);
        check("R6 latch refreshed when disarmed", int'(fetch_addr), 16'h0F04);

        // R7: armed, read one dot before the window is relayed
        cfg_arm = 1'b1;
        push_bus(1800, 1805, 0, 7, "R7 outside window relay");
        run_line(1800, 6, 7, 0, 0, 0);
        check("R7 fire_count outside window", int'(fire_count), 0);
        check("R7 latch refreshed", int'(fetch_addr), 16'h0F04);

        // R2..R6: full intervention; processor touches register 3 during replay
        push_bus(1810, 1815, 0, 0, "R2 swallow");
        push_bus(1816, 1833, 1, 0, "R3 quiet before replay");
        push_bus(1834, 1841, 0, 7, "R3 R4 replay");
        push_bus(1842, 1845, 1, 0, "R3 replay ended");
        push(1824, 2, 1, "R5 strobe before freeze");
        push(1832, 2, 0, "R5 freeze");
        push(1833, 2, 0, "R5 freeze");
        push(1840, 2, 1, "R5 strobe after freeze");
        run_line(1810, 6, 7, 1834, 4, 3);
        check("R2 fire_count", int'(fire_count), 1);
        check("R6 stale fetch address", int'(fetch_addr), 16'h0FFF);
        check("R8 no overlap yet", int'(overlap), 0);

        // R8: second qualifying read during the wait
        cfg_dot_hi = 9'd227;
        push_bus(1810, 1815, 0, 0, "R2 swallow again");
        push_bus(1820, 1823, 0, 7, "R8 overlap relay");
        push_bus(1834, 1841, 0, 7, "R3 replay again");
        run_line(1810, 6, 7, 1820, 4, 7);
        check("R8 fire_count", int'(fire_count), 2);
        check("R8 overlap set", int'(overlap), 1);
        check("R6 stale fetch again", int'(fetch_addr), 16'h0FFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule